// File: doc/BRIEF.md
# Dual-Mode Host Bus Register Interface

This block connects an 8-bit host processor bus to a small register file inside a telecom timing and switching device. One set of pins supports two strobe styles. In Intel style there are separate read and write strobes. In Motorola style there is one data strobe plus a read/write level. Each style can run with a multiplexed address (address and data share the AD lines and are split by an address latch enable) or a non-multiplexed address (a separate 2-bit address input).

The host pins are not related to the internal clock, so all of them pass through a two-flop synchroniser. The block infers the address mode from the latch-enable pin. While that pin stays at a fixed level, the block uses the separate address input. The first falling edge on the pin switches the block to multiplexed operation, and it stays there until reset.

Reads drive the selected register onto the data lines together with an output enable. Writes are committed when the access ends. A handshake enable models the open-drain ready/acknowledge line: it inserts a one-clock wait in Intel style and acts as a held acknowledge in Motorola style.

Top module: `hbus_regif`

## Requirements
- R1: While `cs_n` is high, `ad_oe` and `rdy_oe` are low and no register changes, whatever the strobes do.
- R2: With `ale` held static, `addr_sep` selects the register and the AD lines carry data only.
- R3: The first falling edge of `ale` switches the block to multiplexed mode, and it stays there until reset. In this mode the register index is AD[1:0] as sampled at that falling edge.
- R4: In multiplexed mode, `addr_sep` has no effect on which register is read or written.
- R5: Intel style (`style_moto`=0): `cs_n` low with `rd_ds_n` low drives the addressed register on `ad_out` with `ad_oe` high. `cs_n` low with `wr_rw` low is a write.
- R6: Motorola style (`style_moto`=1): `cs_n` low with `rd_ds_n` low is an access. `wr_rw` high means read and low means write.
- R7: A write is committed to the register when the access deasserts, using the data present while it was active. The register keeps its old value while the strobe is still active.
- R8: In Intel style, `rdy_oe` is high for exactly one clock per access.
- R9: In Motorola style, `rdy_oe` rises during the access, stays high while the access lasts, and falls when the strobe ends. It also drops at once, with no clock, when `cs_n` rises.
- R10: Reset (`rst_n` low at a clock edge) clears every register to zero and returns the block to non-multiplexed mode.
- R11: A write still commits when `cs_n` and the write strobe deassert together.
- R12: `cfg_q` exports the register file, with register k at bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| style_moto | input | 1 | Static strobe style: 0 Intel, 1 Motorola |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address latch enable; static means non-multiplexed |
| addr_sep | input | 2 | Separate register address (non-multiplexed mode) |
| rd_ds_n | input | 1 | Read strobe (Intel) or data strobe (Motorola), active low |
| wr_rw | input | 1 | Write strobe active low (Intel) or read/write level (Motorola) |
| ad_in | input | 8 | AD bus value seen at the pins |
| ad_out | output | 8 | Read data for the AD bus |
| ad_oe | output | 1 | AD bus output enable |
| rdy_oe | output | 1 | Pull-down enable for the ready/acknowledge line |
| cfg_q | output | 32 | Register file contents |

## Verification
Two functions can fall in the same clock: the write commit and the release of the handshake when chip select deasserts. The bench provokes this by raising `cs_n` and the write strobe on the same edge. It then judges the result in two ways: `rdy_oe` must be low immediately, and the value written must appear in `cfg_q` and on a later read. A second overlap is the capture of the address at the falling edge of `ale` while `addr_sep` holds a conflicting value. This is judged by which register changes.

// File: rtl/hbus_pkg.sv
// Package: shared types for the host bus register interface.
// Assumes: the strobe style is a static strap that is stable out of reset.
package hbus_pkg;
    typedef enum logic {
        STY_INTEL = 1'b0,
        STY_MOTO  = 1'b1
    } style_e;
endpackage

// File: rtl/hbus_sync.sv
// Two-flop synchroniser, one chain per bit, each bit with its own reset level.
// Assumes: each bit is treated independently; the host holds its buses
// stable long enough that skew between bits settles within a clock.
module hbus_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        // two-stage resampling of one asynchronous pin into clk
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/hbus_decode.sv
// Access decoder: infers the address mode from the latch-enable pin, latches
// the multiplexed address and turns the strobes into read/write activity.
// Assumes: all inputs are already synchronised to clk.
module hbus_decode
    import hbus_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  style_e        style,
    input  logic          cs_n_s,
    input  logic          rd_ds_n_s,
    input  logic          wr_rw_s,
    input  logic          ale_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] ad_s,
    output logic          mux_mode,
    output logic [AW-1:0] eff_addr,
    output logic          rd_act,
    output logic          wr_act
);
    logic          ale_q;
    logic          ale_fall;
    logic [AW-1:0] addr_lat;

    assign ale_fall = ale_q & ~ale_s;

    // remember previous latch-enable level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ale_q <= 1'b0;
        else        ale_q <= ale_s;
    end

    // sticky multiplexed-mode flag and address capture on latch-enable fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_mode <= 1'b0;
            addr_lat <= '0;
        end else if (ale_fall) begin
            mux_mode <= 1'b1;
            addr_lat <= ad_s[AW-1:0];
        end
    end

    // pick the address source for the current access
    assign eff_addr = mux_mode ? addr_lat : addr_s;

    // strobe decode for both styles
    always_comb begin
        if (style == STY_MOTO) begin
            rd_act = ~cs_n_s & ~rd_ds_n_s &  wr_rw_s;
            wr_act = ~cs_n_s & ~rd_ds_n_s & ~wr_rw_s;
        end else begin
            rd_act = ~cs_n_s & ~rd_ds_n_s;
            wr_act = ~cs_n_s & ~wr_rw_s;
        end
    end
endmodule

// File: rtl/hbus_regfile.sv
// Register file: holds write address/data during a write and commits them
// when the write ends; provides an asynchronous read port.
// Assumes: wr_act is a synchronised level, high for the whole write.
module hbus_regfile #(
    parameter int NREG = 4,
    parameter int DW   = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_act,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic               commit,
    output logic [NREG*DW-1:0] regs_flat
);
    logic [DW-1:0] regs [NREG];
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_data;
    logic          wr_act_q;

    assign commit = wr_act_q & ~wr_act;

    // track write activity and keep the last address/data seen while active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_q  <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
        end else begin
            wr_act_q <= wr_act;
            if (wr_act) begin
                hold_addr <= addr;
                hold_data <= wdata;
            end
        end
    end

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        // one register, cleared on reset, loaded on the write commit
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[k] <= '0;
            else if (commit && hold_addr == AW'(k))
                regs[k] <= hold_data;
        end
        assign regs_flat[k*DW +: DW] = regs[k];
    end

    assign rdata = regs[addr];
endmodule

// File: rtl/hbus_regif.sv
// Top: host bus register interface. Synchronises the host pins, decodes the
// access, runs the register file and generates the ready/acknowledge enable.
// Assumes: style_moto is static; the open-drain pads sit outside this block.
module hbus_regif
    import hbus_pkg::*;
#(
    parameter int  NREG = 4,
    parameter int  DW   = 8,
    localparam int AW   = $clog2(NREG),
    localparam int SW   = 4 + AW + DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               style_moto,
    input  logic               cs_n,
    input  logic               ale,
    input  logic [AW-1:0]      addr_sep,
    input  logic               rd_ds_n,
    input  logic               wr_rw,
    input  logic [DW-1:0]      ad_in,
    output logic [DW-1:0]      ad_out,
    output logic               ad_oe,
    output logic               rdy_oe,
    output logic [NREG*DW-1:0] cfg_q
);
    localparam logic [SW-1:0] IDLE_PINS = {3'b111, 1'b0, {AW{1'b0}}, {DW{1'b0}}};

    style_e        style;
    logic [SW-1:0] pins_s;
    logic          cs_n_s, rd_ds_n_s, wr_rw_s, ale_s;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] ad_s;
    logic          mux_mode;
    logic [AW-1:0] eff_addr;
    logic          rd_act, wr_act, acc, acc_q, hs_q, commit;

    assign style = style_e'(style_moto);

    hbus_sync #(.W(SW), .RST_VAL(IDLE_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, rd_ds_n, wr_rw, ale, addr_sep, ad_in}),
        .q     (pins_s)
    );
    assign {cs_n_s, rd_ds_n_s, wr_rw_s, ale_s, addr_s, ad_s} = pins_s;

    hbus_decode #(.AW(AW), .DW(DW)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .style     (style),
        .cs_n_s    (cs_n_s),
        .rd_ds_n_s (rd_ds_n_s),
        .wr_rw_s   (wr_rw_s),
        .ale_s     (ale_s),
        .addr_s    (addr_s),
        .ad_s      (ad_s),
        .mux_mode  (mux_mode),
        .eff_addr  (eff_addr),
        .rd_act    (rd_act),
        .wr_act    (wr_act)
    );

    hbus_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_act    (wr_act),
        .addr      (eff_addr),
        .wdata     (ad_s),
        .rdata     (ad_out),
        .commit    (commit),
        .regs_flat (cfg_q)
    );

    assign acc = rd_act | wr_act;

    // handshake: one-clock wait in Intel style, held acknowledge in Motorola style
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
            hs_q  <= 1'b0;
        end else begin
            acc_q <= acc;
            hs_q  <= (style == STY_MOTO) ? acc : (acc & ~acc_q);
        end
    end

    // raw chip select gates both drivers so they release without a clock
    assign rdy_oe = hs_q & ~cs_n;
    assign ad_oe  = rd_act & ~cs_n;
endmodule

// File: rtl/hbus_regif_chk.sv
// Checker: properties over the host bus interface, bound to the top.
// Assumes: connected by the bind below to the top's ports and internal nets.
module hbus_regif_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs_n,
    input logic         style_moto,
    input logic         rdy_oe,
    input logic         ad_oe,
    input logic         mux_mode,
    input logic         commit,
    input logic [W-1:0] cfg_q
);
    AST_CS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!rdy_oe && !ad_oe));                                   // R1
    AST_CS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |=> $stable(cfg_q)); // R1
    AST_MUX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mux_mode |=> mux_mode);                                          // R3
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cfg_q));                                     // R7
    AST_RDY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!style_moto && rdy_oe) |=> !rdy_oe);                            // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (cfg_q == '0 && !mux_mode));                          // R10
endmodule

bind hbus_regif hbus_regif_chk #(.W(NREG*DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .style_moto (style_moto),
    .rdy_oe     (rdy_oe),
    .ad_oe      (ad_oe),
    .mux_mode   (mux_mode),
    .commit     (commit),
    .cfg_q      (cfg_q)
);

// File: tb/hbus_regif_test.sv
// Directed bench: one task per scenario, each checking its own results.
module hbus_regif_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        style_moto;
    logic        cs_n, ale, rd_ds_n, wr_rw;
    logic [1:0]  addr_sep;
    logic [7:0]  ad_in;
    logic [7:0]  ad_out;
    logic        ad_oe, rdy_oe;
    logic [31:0] cfg_q;

    int  n_chk = 0, n_bad = 0, hs_cnt = 0;
    bit  done = 0;
    logic [7:0] model [4];

    always #4 clk = ~clk;

    hbus_regif uut (
        .clk(clk), .rst_n(rst_n), .style_moto(style_moto), .cs_n(cs_n),
        .ale(ale), .addr_sep(addr_sep), .rd_ds_n(rd_ds_n), .wr_rw(wr_rw),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .rdy_oe(rdy_oe),
        .cfg_q(cfg_q)
    );

    // count handshake clocks, sampled away from the active edge
    always @(negedge clk) if (rdy_oe) hs_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_regs(input string req);
        for (int k = 0; k < 4; k++)
            chk(cfg_q[k*8 +: 8] == model[k], req, cfg_q[k*8 +: 8], model[k]);
    endtask

    // multiplexed address phase: AD carries the index, latched on ale fall
    task automatic addr_phase(input logic [1:0] a);
        ad_in = {6'b0, a}; ale = 1'b1; tick(3);
        ale = 1'b0; tick(4);
    endtask

    // one write in either style; addr_sep is driven with a given value
    task automatic do_write(input logic [1:0] a_sep, input logic [7:0] d,
                            input logic [1:0] tgt, input string req);
        hs_cnt = 0;
        addr_sep = a_sep; ad_in = d; cs_n = 1'b0;
        if (style_moto) begin wr_rw = 1'b0; tick(1); rd_ds_n = 1'b0; end
        else            begin tick(1); wr_rw = 1'b0; end
        tick(6);
        chk(cfg_q[tgt*8 +: 8] == model[tgt], {req, " R7 hold"}, cfg_q[tgt*8 +: 8], model[tgt]);
        if (style_moto) begin
            chk(rdy_oe == 1'b1, "R9 ack held", rdy_oe, 1);
            rd_ds_n = 1'b1;
        end else wr_rw = 1'b1;
        tick(5);
        chk(rdy_oe == 1'b0, "R8/R9 released after strobe", rdy_oe, 0);
        cs_n = 1'b1; wr_rw = 1'b1; tick(2);
        model[tgt] = d;
        chk(cfg_q[tgt*8 +: 8] == d, {req, " R7 commit"}, cfg_q[tgt*8 +: 8], d);
        if (style_moto) chk(hs_cnt >= 1, "R9 ack seen", hs_cnt, 1);
        else            chk(hs_cnt == 1, "R8 one wait clock", hs_cnt, 1);
    endtask

    // one read; checks data, enable, and the instant release on cs_n rise
    task automatic do_read(input logic [1:0] a_sep, input logic [1:0] tgt, input string req);
        hs_cnt = 0;
        addr_sep = a_sep; cs_n = 1'b0;
        if (style_moto) begin wr_rw = 1'b1; tick(1); end
        rd_ds_n = 1'b0; tick(6);
        chk(ad_oe == 1'b1, {req, " drive"}, ad_oe, 1);
        chk(ad_out == model[tgt], {req, " data"}, ad_out, model[tgt]);
        if (style_moto) chk(rdy_oe == 1'b1, "R9 ack during read", rdy_oe, 1);
        cs_n = 1'b1; #1;
        chk(rdy_oe == 1'b0 && ad_oe == 1'b0, "R9/R1 instant release", {rdy_oe, ad_oe}, 0);
        tick(1); rd_ds_n = 1'b1; tick(4);
        if (!style_moto) chk(hs_cnt == 1, "R8 one wait clock", hs_cnt, 1);
    endtask

    task automatic t_reset_state;
        chk(cfg_q == 32'h0, "R10 reset regs", cfg_q, 0);
        chk(ad_oe == 1'b0 && rdy_oe == 1'b0, "R1 idle outputs", {ad_oe, rdy_oe}, 0);
    endtask

    task automatic t_intel_nonmux;
        style_moto = 1'b0;
        do_write(2'd1, 8'hA5, 2'd1, "R2 R5 intel write");
        do_write(2'd3, 8'h3C, 2'd3, "R2 R5 intel write");
        check_regs("R12 layout");
        do_read(2'd1, 2'd1, "R5 intel read");
        do_read(2'd0, 2'd0, "R2 intel read zero reg");
    endtask

    task automatic t_moto_nonmux;
        style_moto = 1'b1;
        do_write(2'd2, 8'h5A, 2'd2, "R6 moto write");
        do_read(2'd3, 2'd3, "R6 moto read");
        do_read(2'd2, 2'd2, "R6 moto read");
        style_moto = 1'b0;
    endtask

    task automatic t_cs_high;
        hs_cnt = 0;
        cs_n = 1'b1; addr_sep = 2'd0; ad_in = 8'hFF;
        wr_rw = 1'b0; rd_ds_n = 1'b0; tick(6);
        chk(ad_oe == 1'b0 && rdy_oe == 1'b0, "R1 no drive", {ad_oe, rdy_oe}, 0);
        wr_rw = 1'b1; rd_ds_n = 1'b1; tick(6);
        check_regs("R1 no write");
        chk(hs_cnt == 0, "R1 no handshake", hs_cnt, 0);
    endtask

    task automatic t_mux;
        style_moto = 1'b0;
        addr_phase(2'd0);
        do_write(2'd3, 8'hC3, 2'd0, "R3 R4 mux write");
        check_regs("R4 addr_sep ignored");
        addr_phase(2'd0);
        do_read(2'd1, 2'd0, "R4 mux read");
        style_moto = 1'b1;
        addr_phase(2'd2);
        do_write(2'd1, 8'h77, 2'd2, "R3 moto mux write");
        check_regs("R4 moto addr_sep ignored");
        style_moto = 1'b0;
    endtask

    task automatic t_joint_release;
        style_moto = 1'b0;
        addr_phase(2'd1);
        ad_in = 8'h96; cs_n = 1'b0; tick(1);
        wr_rw = 1'b0; tick(6);
        cs_n = 1'b1; wr_rw = 1'b1; #1;
        chk(rdy_oe == 1'b0, "R11 released", rdy_oe, 0);
        tick(5);
        model[1] = 8'h96;
        chk(cfg_q[15:8] == 8'h96, "R11 commit", cfg_q[15:8], 8'h96);
    endtask

    task automatic t_reset_again;
        rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(2);
        for (int k = 0; k < 4; k++) model[k] = 8'h0;
        chk(cfg_q == 32'h0, "R10 cleared", cfg_q, 0);
        ad_in = 8'h00;
        do_write(2'd2, 8'h42, 2'd2, "R10 back to nonmux");
        check_regs("R10 R2 addr_sep used");
    endtask

    initial begin
        rst_n = 1'b0; style_moto = 1'b0; cs_n = 1'b1; ale = 1'b0;
        rd_ds_n = 1'b1; wr_rw = 1'b1; addr_sep = 2'd0; ad_in = 8'h0;
        for (int k = 0; k < 4; k++) model[k] = 8'h0;
        tick(3); rst_n = 1'b1; tick(3);
        t_reset_state;
        t_intel_nonmux;
        t_moto_nonmux;
        t_cs_high;
        t_mux;
        t_joint_release;
        t_reset_again;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule